// File: doc/BRIEF.md
# Even/Odd Line Request Splitter

This block sits between one load/store requester and two line-wide request ports. Lines are `LINE_BYTES` bytes wide (16 by default). Downstream port 0 owns every line whose lowest line-address bit is 0, which is byte-address bit 4 with the default line size. Port 1 owns every line where that bit is 1. A request carries a byte address, a binary byte count from 1 to `LINE_BYTES` and, for stores, the data. When the access runs past the end of its line it becomes two sub-requests, one on each port. Each sub-request gets its own byte-enable mask and its own slice of the shifted store data.

The upstream side works like a single port. Busy is high for the whole transaction. The address acknowledge or the address exception is a single-cycle pulse, and a load returns one single-cycle data pulse. Downstream ports answer with acknowledge, exception and load-data pulses, which may arrive in different cycles. The block waits for every port that the request uses. It captures each returned load piece and rejoins the pieces into a right-aligned result.

Top module: `ldst_line_splitter`

## Requirements
- R1: While reset is high and in the first cycle after it, up_busy, up_addr_ack, up_addr_exc and up_ld_valid are 0, dn_addr_valid is 0 for both ports, and up_ld_data is 0.
- R2: dn_line[p] carries address bits above the line offset. It is the start line when its lowest bit equals p, and otherwise the next line. A port with dn_addr_valid high always has dn_line[p][0] equal to p.
- R3: The byte mask is ((1<<len)-1) shifted left by the low address offset bits and computed at twice the line width. Its low LINE_BYTES bits go to the port that owns the start line. Its high bits go to the other port. Bit b of dn_be enables byte b of the line.
- R4: When the high mask half is zero, only the start line's port is used. The other port keeps dn_addr_valid, dn_ld, dn_st and dn_st_valid at 0, and its responses are not waited for.
- R5: While up_st_valid is high after the address acknowledge, each used port sees dn_st_valid high in the same cycle. The store data is zero-extended to two lines and shifted left by offset bytes. The low line goes to the start line's port and the high line goes to the other port.
- R6: up_addr_ack is a one-cycle pulse. It comes in the cycle after the last used port has acknowledged, and the acknowledges of the two ports may fall in different cycles.
- R7: An address exception from any used port produces a one-cycle up_addr_exc pulse in the next cycle, with up_busy low in that same cycle. The exception takes precedence over an acknowledge that completes in the same cycle, and no up_addr_ack follows.
- R8: For a load, up_ld_valid pulses for one cycle. The pulse comes in the cycle after the last used piece arrives, and never before the cycle in which up_addr_ack is seen. up_ld_data holds the request's bytes right-aligned, and bytes at positions len and above are zero.
- R9: up_busy rises in the cycle after the request starts and stays high until completion. For a load it falls in the up_ld_valid cycle. For a store it falls in the cycle after up_st_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_ld | input | 1 | Load request, held until busy falls |
| up_st | input | 1 | Store request, held until busy falls |
| up_addr_valid | input | 1 | Address and length valid, held until busy falls |
| up_addr | input | ADDR_W | Byte address |
| up_len | input | LEN_W | Byte count, 1 to LINE_BYTES |
| up_st_valid | input | 1 | One-cycle store data strobe |
| up_st_data | input | LINE_W | Store data, right-aligned |
| up_busy | output | 1 | Transaction in progress |
| up_addr_ack | output | 1 | Address accepted pulse |
| up_addr_exc | output | 1 | Address exception pulse |
| up_ld_valid | output | 1 | Load data valid pulse |
| up_ld_data | output | LINE_W | Joined, right-aligned load data |
| dn_ld | output | 2 | Per-port load request |
| dn_st | output | 2 | Per-port store request |
| dn_addr_valid | output | 2 | Per-port line address valid |
| dn_line | output | 2 x LINE_AW | Per-port line address |
| dn_be | output | 2 x LINE_BYTES | Per-port byte enables |
| dn_st_valid | output | 2 | Per-port store data strobe |
| dn_st_data | output | 2 x LINE_W | Per-port shifted store data |
| dn_addr_ack | input | 2 | Per-port address acknowledge pulse |
| dn_addr_exc | input | 2 | Per-port address exception pulse |
| dn_ld_valid | input | 2 | Per-port load data pulse |
| dn_ld_data | input | 2 x LINE_W | Per-port load line data |

## Verification
Address completion and abort can fall in the same cycle. The bench sets this up on a line-crossing load by pulsing an acknowledge on one port and an exception on the other in one cycle. It then requires an exception pulse with busy low and no acknowledge. The line-crossing cases use a staggered flag for acknowledges and load pieces. With the flag set, the bench confirms that neither upstream pulse appears while one port is still outstanding. With the flag clear, both ports respond in one cycle, and the joined data is compared with a byte-level reference image kept by the bench.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;
  localparam int N_PORTS = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;
endpackage

// File: rtl/lsplit_lanes.sv
// Byte-lane arithmetic: mask and store data placed across a pair of lines.
module lsplit_lanes #(
  parameter  int LINE_BYTES = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LEN_W  = OFF_W + 1,
  localparam int LINE_W = 8 * LINE_BYTES,
  localparam int PAIR_B = 2 * LINE_BYTES,
  localparam int PAIR_W = 2 * LINE_W
) (
  input  logic [OFF_W-1:0]      off,
  input  logic [LEN_W-1:0]      len,
  input  logic [LINE_W-1:0]     st_data,
  output logic [LINE_BYTES-1:0] be_lo,
  output logic [LINE_BYTES-1:0] be_hi,
  output logic [LINE_W-1:0]     data_lo,
  output logic [LINE_W-1:0]     data_hi,
  output logic [LINE_BYTES-1:0] keep
);
  logic [PAIR_B-1:0] len_mask;
  logic [PAIR_B-1:0] be_pair;
  logic [PAIR_W-1:0] data_pair;

  always_comb begin
    len_mask  = (PAIR_B'(1) << len) - PAIR_B'(1);
    be_pair   = len_mask << off;
    data_pair = {LINE_W'(0), st_data} << {off, 3'b000};
  end

  assign be_lo   = be_pair[LINE_BYTES-1:0];
  assign be_hi   = be_pair[PAIR_B-1:LINE_BYTES];
  assign data_lo = data_pair[LINE_W-1:0];
  assign data_hi = data_pair[PAIR_W-1:LINE_W];
  assign keep    = len_mask[LINE_BYTES-1:0];
endmodule

// File: rtl/lsplit_route.sv
// Steers the start line and the next line onto the port matching their parity.
module lsplit_route #(
  parameter  int ADDR_W     = 16,
  parameter  int LINE_BYTES = 16,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int LINE_AW = ADDR_W - OFF_W,
  localparam int LINE_W  = 8 * LINE_BYTES
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [LINE_BYTES-1:0]             be_lo,
  input  logic [LINE_BYTES-1:0]             be_hi,
  input  logic [LINE_W-1:0]                 data_lo,
  input  logic [LINE_W-1:0]                 data_hi,
  output logic [1:0][LINE_AW-1:0]           line,
  output logic [1:0][LINE_BYTES-1:0]        be,
  output logic [1:0][LINE_W-1:0]            data,
  output logic [1:0]                        used,
  output logic                              first_port
);
  logic [LINE_AW-1:0] start_line;
  logic [LINE_AW-1:0] next_line;
  logic               crosses;

  assign start_line = addr[ADDR_W-1:OFF_W];
  assign next_line  = start_line + LINE_AW'(1);
  assign crosses    = |be_hi;
  assign first_port = start_line[0];

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic is_first;
    assign is_first = (first_port == p[0]);
    assign line[p]  = is_first ? start_line : next_line;
    assign be[p]    = is_first ? be_lo : be_hi;
    assign data[p]  = is_first ? data_lo : data_hi;
    assign used[p]  = is_first | crosses;
  end
endmodule

// File: rtl/lsplit_join.sv
// Rejoins two returned line pieces into one right-aligned result.
module lsplit_join #(
  parameter  int LINE_BYTES = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = 8 * LINE_BYTES,
  localparam int PAIR_W = 2 * LINE_W
) (
  input  logic [LINE_W-1:0]     first,
  input  logic [LINE_W-1:0]     second,
  input  logic [OFF_W-1:0]      off,
  input  logic [LINE_BYTES-1:0] keep,
  output logic [LINE_W-1:0]     joined
);
  logic [PAIR_W-1:0] pair_sh;
  logic [LINE_W-1:0] keep_bits;

  assign pair_sh = {second, first} >> {off, 3'b000};

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_keep
    assign keep_bits[8*b +: 8] = {8{keep[b]}};
  end

  assign joined = pair_sh[LINE_W-1:0] & keep_bits;
endmodule

// File: rtl/lsplit_ctrl.sv
// Transaction sequencing: response tracking, piece capture, upstream pulses.
module lsplit_ctrl
  import lsplit_pkg::*;
#(
  parameter int LINE_W = 128
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   up_ld,
  input  logic                   up_st,
  input  logic                   up_addr_valid,
  input  logic                   up_st_valid,
  input  logic [1:0]             used,
  input  logic [1:0]             dn_addr_ack,
  input  logic [1:0]             dn_addr_exc,
  input  logic [1:0]             dn_ld_valid,
  input  logic [1:0][LINE_W-1:0] dn_ld_data,
  input  logic [LINE_W-1:0]      joined,
  output logic [1:0][LINE_W-1:0] cur_piece,
  output logic                   active,
  output logic                   in_data,
  output logic                   op_ld,
  output logic                   busy,
  output logic                   addr_ack,
  output logic                   addr_exc,
  output logic                   ld_valid,
  output logic [LINE_W-1:0]      ld_data
);
  phase_t                 phase_q;
  logic                   busy_q, op_ld_q;
  logic                   ack_q, exc_q, ldv_q;
  logic [LINE_W-1:0]      ld_data_q;
  logic [1:0]             ackd_q, got_q;
  logic [1:0][LINE_W-1:0] hold_q;

  logic [1:0] ack_now, got_now, ld_in;
  logic       all_ack, all_got, exc_now;

  assign active  = (phase_q != PH_IDLE);
  assign in_data = (phase_q == PH_DATA);

  always_comb begin
    ack_now = ackd_q | (dn_addr_ack & used & {2{up_addr_valid}});
    all_ack = &(ack_now | ~used);
    exc_now = up_addr_valid & |(dn_addr_exc & used);
    ld_in   = dn_ld_valid & used & {2{active}};
    got_now = got_q | ld_in;
    all_got = &(got_now | ~used);
  end

  for (genvar p = 0; p < 2; p++) begin : g_piece
    assign cur_piece[p] = ld_in[p] ? dn_ld_data[p] : hold_q[p];

    always_ff @(posedge clk) begin
      if (ld_in[p]) hold_q[p] <= dn_ld_data[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      busy_q    <= 1'b0;
      op_ld_q   <= 1'b0;
      ack_q     <= 1'b0;
      exc_q     <= 1'b0;
      ldv_q     <= 1'b0;
      ld_data_q <= '0;
      ackd_q    <= '0;
      got_q     <= '0;
    end else begin
      ack_q <= 1'b0;
      exc_q <= 1'b0;
      ldv_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (up_ld | up_st) begin
            phase_q <= PH_ADDR;
            busy_q  <= 1'b1;
            op_ld_q <= up_ld;
            ackd_q  <= '0;
            got_q   <= '0;
          end
        end
        PH_ADDR: begin
          ackd_q <= ack_now;
          got_q  <= got_now;
          if (exc_now) begin
            exc_q   <= 1'b1;
            busy_q  <= 1'b0;
            phase_q <= PH_IDLE;
          end else if (up_addr_valid && all_ack) begin
            ack_q   <= 1'b1;
            phase_q <= PH_DATA;
          end
        end
        PH_DATA: begin
          got_q <= got_now;
          if (op_ld_q && all_got) begin
            ldv_q     <= 1'b1;
            ld_data_q <= joined;
            busy_q    <= 1'b0;
            phase_q   <= PH_IDLE;
          end else if (!op_ld_q && up_st_valid) begin
            busy_q  <= 1'b0;
            phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign op_ld    = op_ld_q;
  assign busy     = busy_q;
  assign addr_ack = ack_q;
  assign addr_exc = exc_q;
  assign ld_valid = ldv_q;
  assign ld_data  = ld_data_q;
endmodule

// File: rtl/ldst_line_splitter.sv
module ldst_line_splitter #(
  parameter  int ADDR_W     = 16,
  parameter  int LINE_BYTES = 16,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int LEN_W   = OFF_W + 1,
  localparam int LINE_AW = ADDR_W - OFF_W,
  localparam int LINE_W  = 8 * LINE_BYTES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       up_ld,
  input  logic                       up_st,
  input  logic                       up_addr_valid,
  input  logic [ADDR_W-1:0]          up_addr,
  input  logic [LEN_W-1:0]           up_len,
  input  logic                       up_st_valid,
  input  logic [LINE_W-1:0]          up_st_data,
  output logic                       up_busy,
  output logic                       up_addr_ack,
  output logic                       up_addr_exc,
  output logic                       up_ld_valid,
  output logic [LINE_W-1:0]          up_ld_data,
  output logic [1:0]                 dn_ld,
  output logic [1:0]                 dn_st,
  output logic [1:0]                 dn_addr_valid,
  output logic [1:0][LINE_AW-1:0]    dn_line,
  output logic [1:0][LINE_BYTES-1:0] dn_be,
  output logic [1:0]                 dn_st_valid,
  output logic [1:0][LINE_W-1:0]     dn_st_data,
  input  logic [1:0]                 dn_addr_ack,
  input  logic [1:0]                 dn_addr_exc,
  input  logic [1:0]                 dn_ld_valid,
  input  logic [1:0][LINE_W-1:0]     dn_ld_data
);
  logic [OFF_W-1:0]       off;
  logic [LINE_BYTES-1:0]  be_lo, be_hi, keep;
  logic [LINE_W-1:0]      data_lo, data_hi, joined;
  logic [1:0]             used;
  logic                   first_port;
  logic [1:0][LINE_W-1:0] cur_piece;
  logic                   active, in_data, op_ld;

  assign off = up_addr[OFF_W-1:0];

  lsplit_lanes #(.LINE_BYTES(LINE_BYTES)) lanes_i (
    .off(off), .len(up_len), .st_data(up_st_data),
    .be_lo(be_lo), .be_hi(be_hi), .data_lo(data_lo), .data_hi(data_hi),
    .keep(keep)
  );

  lsplit_route #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) route_i (
    .addr(up_addr), .be_lo(be_lo), .be_hi(be_hi),
    .data_lo(data_lo), .data_hi(data_hi),
    .line(dn_line), .be(dn_be), .data(dn_st_data),
    .used(used), .first_port(first_port)
  );

  lsplit_join #(.LINE_BYTES(LINE_BYTES)) join_i (
    .first(cur_piece[first_port]), .second(cur_piece[~first_port]),
    .off(off), .keep(keep), .joined(joined)
  );

  lsplit_ctrl #(.LINE_W(LINE_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .up_ld(up_ld), .up_st(up_st),
    .up_addr_valid(up_addr_valid), .up_st_valid(up_st_valid),
    .used(used),
    .dn_addr_ack(dn_addr_ack), .dn_addr_exc(dn_addr_exc),
    .dn_ld_valid(dn_ld_valid), .dn_ld_data(dn_ld_data),
    .joined(joined), .cur_piece(cur_piece),
    .active(active), .in_data(in_data), .op_ld(op_ld),
    .busy(up_busy), .addr_ack(up_addr_ack), .addr_exc(up_addr_exc),
    .ld_valid(up_ld_valid), .ld_data(up_ld_data)
  );

  for (genvar p = 0; p < 2; p++) begin : g_dn
    assign dn_ld[p]         = active & op_ld & used[p];
    assign dn_st[p]         = active & ~op_ld & used[p];
    assign dn_addr_valid[p] = active & up_addr_valid & used[p];
    assign dn_st_valid[p]   = in_data & ~op_ld & up_st_valid & used[p];
  end
endmodule

// File: rtl/lsplit_checker.sv
module lsplit_checker #(
  parameter int LINE_AW = 12,
  parameter int LB      = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 up_busy,
  input logic                 up_addr_ack,
  input logic                 up_addr_exc,
  input logic                 up_ld_valid,
  input logic                 up_st_valid,
  input logic [1:0]           dn_st,
  input logic [1:0]           dn_addr_valid,
  input logic [1:0][LINE_AW-1:0] dn_line,
  input logic [1:0][LB-1:0]   dn_be,
  input logic [1:0]           dn_st_valid
);
  a_r2_port0_even: assert property (@(posedge clk) disable iff (rst)
    dn_addr_valid[0] |-> (dn_line[0][0] == 1'b0));
  a_r2_port1_odd: assert property (@(posedge clk) disable iff (rst)
    dn_addr_valid[1] |-> (dn_line[1][0] == 1'b1));
  a_r3_port0_mask_live: assert property (@(posedge clk) disable iff (rst)
    dn_addr_valid[0] |-> (dn_be[0] != '0));
  a_r3_port1_mask_live: assert property (@(posedge clk) disable iff (rst)
    dn_addr_valid[1] |-> (dn_be[1] != '0));
  a_r5_strobe_needs_store: assert property (@(posedge clk) disable iff (rst)
    (dn_st_valid & ~dn_st) == 2'b00);
  a_r6_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    up_addr_ack |=> !up_addr_ack);
  a_r7_exc_ends_busy: assert property (@(posedge clk) disable iff (rst)
    up_addr_exc |-> (!up_busy && !up_addr_ack));
  a_r8_ld_ends_busy: assert property (@(posedge clk) disable iff (rst)
    up_ld_valid |-> !up_busy);
  a_r9_st_then_idle: assert property (@(posedge clk) disable iff (rst)
    (up_busy && up_st_valid && (dn_st_valid != 2'b00)) |=> !up_busy);
endmodule

bind ldst_line_splitter lsplit_checker #(.LINE_AW(LINE_AW), .LB(LINE_BYTES)) chk_i (
  .clk(clk), .rst(rst),
  .up_busy(up_busy), .up_addr_ack(up_addr_ack), .up_addr_exc(up_addr_exc),
  .up_ld_valid(up_ld_valid), .up_st_valid(up_st_valid),
  .dn_st(dn_st), .dn_addr_valid(dn_addr_valid), .dn_line(dn_line),
  .dn_be(dn_be), .dn_st_valid(dn_st_valid)
);

// File: tb/ldst_line_splitter_tb_top.sv
module ldst_line_splitter_tb_top;
  localparam int ADDR_W = 16;
  localparam int LB     = 16;
  localparam int LAW    = ADDR_W - 4;
  localparam int LW     = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              up_ld = 0, up_st = 0, up_addr_valid = 0, up_st_valid = 0;
  logic [ADDR_W-1:0] up_addr = '0;
  logic [4:0]        up_len = '0;
  logic [LW-1:0]     up_st_data = '0;
  logic              up_busy, up_addr_ack, up_addr_exc, up_ld_valid;
  logic [LW-1:0]     up_ld_data;
  logic [1:0]        dn_ld, dn_st, dn_addr_valid, dn_st_valid;
  logic [1:0][LAW-1:0] dn_line;
  logic [1:0][LB-1:0]  dn_be;
  logic [1:0][LW-1:0]  dn_st_data;
  logic [1:0]        dn_addr_ack = 0, dn_addr_exc = 0, dn_ld_valid = 0;
  logic [1:0][LW-1:0] dn_ld_data = '0;

  ldst_line_splitter #(.ADDR_W(ADDR_W), .LINE_BYTES(LB)) dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] bmem [256];
  logic [7:0] bref [256];

  // {addr[7:0], len[4:0], staggered}
  localparam logic [13:0] VEC [8] = '{
    {8'h02, 5'd4,  1'b0}, {8'h0E, 5'd4,  1'b1}, {8'h1C, 5'd8,  1'b0},
    {8'h10, 5'd16, 1'b0}, {8'h00, 5'd16, 1'b1}, {8'h1F, 5'd1,  1'b0},
    {8'h21, 5'd16, 1'b1}, {8'h3F, 5'd2,  1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] line_of(input logic [3:0] ln);
    logic [LW-1:0] r;
    for (int b = 0; b < LB; b++) r[8*b +: 8] = bmem[{ln, 4'(b)}];
    return r;
  endfunction

  // drive the request, then check the downstream request fields (R2 R3 R4)
  task automatic start_req(input bit is_ld, input logic [7:0] a, input logic [4:0] len,
                           output logic [1:0] used, output bit fp);
    logic [31:0] m;
    m  = ((32'd1 << len) - 32'd1) << a[3:0];
    fp = a[4];
    @(negedge clk);
    up_ld = is_ld; up_st = !is_ld; up_addr_valid = 1'b1;
    up_addr = {8'h00, a}; up_len = len;
    @(negedge clk);
    chk(up_busy == 1'b1, "R9 busy rises", LW'(up_busy), LW'(1));
    for (int p = 0; p < 2; p++) begin
      bit first;
      bit ev;
      first = (p == int'(fp));
      ev = first || (m[31:16] != 0);
      used[p] = ev;
      chk(dn_addr_valid[p] == ev && (is_ld ? dn_ld[p] : dn_st[p]) == ev,
          "R4 port use", LW'({dn_addr_valid[p], dn_ld[p], dn_st[p]}), LW'(ev));
      if (ev) begin
        chk(dn_be[p] == (first ? m[15:0] : m[31:16]), "R3 byte mask",
            LW'(dn_be[p]), LW'(first ? m[15:0] : m[31:16]));
        chk(dn_line[p] == LAW'(a[7:4]) + (first ? LAW'(0) : LAW'(1)), "R2 line",
            LW'(dn_line[p]), LW'(LAW'(a[7:4]) + (first ? LAW'(0) : LAW'(1))));
      end
    end
  endtask

  // acknowledges from the used ports; staggered puts them one cycle apart (R6)
  task automatic acks(input logic [1:0] used, input bit fp, input bit stag);
    if (stag && used == 2'b11) begin
      dn_addr_ack[fp] = 1'b1;
      @(negedge clk);
      dn_addr_ack = '0;
      chk(up_addr_ack == 1'b0, "R6 no ack while one port pending", LW'(up_addr_ack), 0);
      dn_addr_ack[!fp] = 1'b1;
    end else begin
      dn_addr_ack = used;
    end
    @(negedge clk);
    dn_addr_ack = '0;
    chk(up_addr_ack == 1'b1, "R6 upstream ack", LW'(up_addr_ack), LW'(1));
  endtask

  task automatic do_store(input logic [7:0] a, input logic [4:0] len,
                          input logic [LW-1:0] d, input bit stag);
    logic [1:0] used;
    bit fp;
    logic [2*LW-1:0] pr;
    start_req(1'b0, a, len, used, fp);
    acks(used, fp, stag);
    up_st_valid = 1'b1; up_st_data = d;
    pr = {LW'(0), d} << {a[3:0], 3'b000};
    #1;
    for (int p = 0; p < 2; p++) begin
      logic [LW-1:0] ed;
      ed = (p == int'(fp)) ? pr[LW-1:0] : pr[2*LW-1:LW];
      chk(dn_st_valid[p] == used[p], "R5 store strobe", LW'(dn_st_valid[p]), LW'(used[p]));
      if (used[p]) begin
        chk(dn_st_data[p] == ed, "R5 store data", dn_st_data[p], ed);
        for (int b = 0; b < LB; b++)
          if (dn_be[p][b]) bmem[{dn_line[p][3:0], 4'(b)}] = dn_st_data[p][8*b +: 8];
      end
    end
    for (int i = 0; i < 32; i++)
      if (i < int'(len)) bref[8'(int'(a) + i)] = d[8*i +: 8];
    @(negedge clk);
    up_st_valid = 1'b0; up_st = 1'b0; up_addr_valid = 1'b0;
    chk(up_busy == 1'b0, "R9 busy falls after store strobe", LW'(up_busy), 0);
  endtask

  task automatic do_load(input logic [7:0] a, input logic [4:0] len, input bit stag);
    logic [1:0] used;
    bit fp;
    logic [LW-1:0] e;
    start_req(1'b1, a, len, used, fp);
    acks(used, fp, stag);
    for (int p = 0; p < 2; p++) dn_ld_data[p] = line_of(dn_line[p][3:0]);
    if (stag && used == 2'b11) begin
      dn_ld_valid[fp] = 1'b1;
      @(negedge clk);
      dn_ld_valid = '0;
      chk(up_ld_valid == 1'b0 && up_busy == 1'b1, "R8 no data with piece missing",
          LW'({up_ld_valid, up_busy}), LW'(1));
      dn_ld_valid[!fp] = 1'b1;
    end else begin
      dn_ld_valid = used;
    end
    @(negedge clk);
    dn_ld_valid = '0;
    e = '0;
    for (int i = 0; i < LB; i++)
      if (i < int'(len)) e[8*i +: 8] = bref[8'(int'(a) + i)];
    chk(up_ld_valid == 1'b1 && up_busy == 1'b0, "R8 R9 load done",
        LW'({up_ld_valid, up_busy}), LW'(2));
    chk(up_ld_data == e, "R8 load data", up_ld_data, e);
    up_ld = 1'b0; up_addr_valid = 1'b0;
    @(negedge clk);
    chk(up_ld_valid == 1'b0, "R8 single pulse", LW'(up_ld_valid), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [1:0] used;
    bit fp;
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'(i ^ 8'h5A);
      bref[i] = 8'(i ^ 8'h5A);
    end
    repeat (3) @(negedge clk);
    chk({up_busy, up_addr_ack, up_addr_exc, up_ld_valid, dn_addr_valid} == '0 && up_ld_data == '0,
        "R1 reset state", LW'({up_busy, up_addr_ack, up_addr_exc, up_ld_valid, dn_addr_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({up_busy, up_addr_ack, up_addr_exc, up_ld_valid, dn_addr_valid} == '0,
        "R1 idle after reset", LW'({up_busy, up_addr_ack, up_addr_exc, up_ld_valid}), 0);

    for (int k = 0; k < 8; k++) begin
      logic [LW-1:0] d;
      for (int j = 0; j < LB; j++) d[8*j +: 8] = 8'(k * 17 + j * 3 + 1);
      do_store(VEC[k][13:6], VEC[k][5:1], d, VEC[k][0]);
    end
    for (int k = 0; k < 8; k++) do_load(VEC[k][13:6], VEC[k][5:1], VEC[k][0]);

    // R7: acknowledge on one port and exception on the other in one cycle
    start_req(1'b1, 8'h0C, 5'd8, used, fp);
    dn_addr_ack[0] = 1'b1; dn_addr_exc[1] = 1'b1;
    @(negedge clk);
    dn_addr_ack = '0; dn_addr_exc = '0;
    chk(up_addr_exc == 1'b1 && up_addr_ack == 1'b0 && up_busy == 1'b0, "R7 abort wins",
        LW'({up_addr_exc, up_addr_ack, up_busy}), LW'(4));
    up_ld = 1'b0; up_addr_valid = 1'b0;
    @(negedge clk);
    chk(up_addr_exc == 1'b0 && dn_addr_valid == 2'b00, "R7 single exc pulse",
        LW'({up_addr_exc, dn_addr_valid}), 0);

    // R6 R9: slow acknowledge on a single-line store; unused port stays idle (R4)
    start_req(1'b0, 8'h44, 5'd4, used, fp);
    repeat (3) begin
      @(negedge clk);
      chk(up_busy == 1'b1 && up_addr_ack == 1'b0, "R6 waits for port", LW'({up_busy, up_addr_ack}), LW'(2));
      chk(dn_addr_valid[1] == 1'b0 && dn_st[1] == 1'b0, "R4 idle port", LW'({dn_addr_valid[1], dn_st[1]}), 0);
    end
    acks(used, fp, 1'b0);
    up_st_valid = 1'b1; up_st_data = LW'(32'hA1B2C3D4);
    #1;
    chk(dn_st_valid == 2'b01, "R4 R5 strobe on used port only", LW'(dn_st_valid), LW'(1));
    for (int b = 0; b < LB; b++)
      if (dn_be[0][b]) bmem[{dn_line[0][3:0], 4'(b)}] = dn_st_data[0][8*b +: 8];
    for (int i = 0; i < 4; i++) bref[8'(8'h44 + i)] = up_st_data[8*i +: 8];
    @(negedge clk);
    up_st_valid = 1'b0; up_st = 1'b0; up_addr_valid = 1'b0;
    chk(up_busy == 1'b0, "R9 busy falls", LW'(up_busy), 0);
    do_load(8'h43, 5'd6, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule